// File: doc/BRIEF.md
# MSI-X Capability Control and Replay Sequencer

This block holds the three-dword MSI-X capability structure in a function's configuration space and reacts to software writes of its control byte. Elaboration parameters give the number of vectors, the BAR that carries the vector table and the BAR's size before the capability is added. From these the block computes where the table and the pending-bit array sit (both directly above the original BAR contents, pending bits half a page above the table) and the enlarged BAR size that the BAR logic must advertise.

Software reaches the capability over a dword-addressed, byte-enabled configuration port. Reads return data in the same cycle as the address. A write that covers the control byte latches the enable and function-mask bits. The cycle after it, the block pulses a request to drop the legacy interrupt line if MSI-X is on. If the function is then enabled and unmasked, the block also streams vector numbers 0 to N-1, one per handshake, to the vector table, which checks each vector for a pending message to release. The replay stream is valid/ready. While `rply_ready` is low, the offered vector is held and `rply_valid` stays high. A vector counts as delivered only in a cycle where both are high. The scan never drops or skips a vector because of back-pressure. `busy` is high for the whole scan.

An illegal parameter set (vector count outside 1 to 2048, or an original BAR size above 0x8000_0000) flags a configuration error and hides the capability.

Top module: `msix_cap_ctrl`

## Requirements
- R1: The dword at the capability pointer reads {enable[31], mask_all[30], 3'b000, NUM_VEC-1 in [26:16], next pointer in [15:8], 8'h11 in [7:0]}; `cfg_hit` is high for the three capability dwords only, and `cfg_rdata` is 0 elsewhere.
- R2: Only bits 31 (enable) and 30 (mask_all) are writable, and only by a write to the first capability dword with byte lane 3 enabled (`cfg_be[3]`); the levels appear on `msix_en`/`mask_all` the cycle after.
- R3: The dword at pointer+4 reads the adjusted BAR size OR'ed with the BAR number in bits [2:0]; the dword at pointer+8 reads the adjusted size plus 0x800 OR'ed with the BAR number.
- R4: BAR sizing: original size 0 gives adjusted size 0 and `bar_size` 0x1000; a size in 1..0xFFF gives adjusted size 0x1000 and `bar_size` 0x2000; any larger size S gives adjusted size S and `bar_size` 2*S.
- R5: With NUM_VEC outside 1..2048 or original size above 0x8000_0000, `cfg_err` is 1, `bar_size` is 0, `cfg_hit` and `cfg_rdata` are 0, and writes start nothing.
- R6: After reset, enable and mask_all are 0, `busy` and `rply_valid` are 0 and `intx_clear` is 0.
- R7: One cycle after a control write, `intx_clear` is high for exactly one cycle if the written enable bit is 1, and stays low otherwise.
- R8: A control write that leaves the function enabled and unmasked starts a scan: `rply_vec` takes 0, 1, ... N-1 in order, one step per accepted handshake; `busy` and `rply_valid` rise the cycle after the write and fall the cycle after the last vector is accepted.
- R9: While `rply_valid` is high and `rply_ready` is low, `rply_valid` stays high and `rply_vec` holds.
- R10: A control write during a scan restarts it at vector 0 if it leaves the function enabled and unmasked, and ends it (valid and busy low next cycle) otherwise.
- R11: A write without lane 3, or to any other address, changes neither control bit and produces no `intx_clear` pulse and no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration dword address |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| cfg_hit | output | 1 | `cfg_addr` selects a capability dword |
| cfg_err | output | 1 | Illegal parameter set |
| bar_size | output | 33 | Enlarged BAR size |
| msix_en | output | 1 | MSI-X enable level |
| mask_all | output | 1 | Function mask level |
| intx_clear | output | 1 | One-cycle request to deassert the legacy interrupt |
| busy | output | 1 | Replay scan in progress |
| rply_valid | output | 1 | Replay vector offered |
| rply_ready | input | 1 | Vector table accepts the offered vector |
| rply_vec | output | VEC_W | Offered vector number |

## Verification
The bench sweeps all sixteen byte-enable patterns against all four enable/mask values. A design that decoded the wrong lane, or reacted to writes that miss the control byte, would change the control bits, pulse `intx_clear` or start a scan where none is due. Scans run under always-ready, alternating and sparse ready patterns. A sequencer that advanced on valid alone, or skipped or repeated a vector, breaks the expected 0..N-1 order or the count. A single-vector instance checks that a one-step scan ends at once. Mid-scan writes check that a restart returns to vector 0 and that masking or disabling ends the scan. Four parameter sets cover every BAR-sizing branch and the error case. A design that skipped the 4 KB floor, or placed the pending array wrongly, reads back the wrong offset dwords.

// File: rtl/msixc_pkg.sv
package msixc_pkg;

  localparam logic [7:0]  CAP_ID     = 8'h11;
  localparam logic [63:0] PAGE_BYTES = 64'h1000;
  localparam logic [63:0] PBA_SHIFT  = 64'h800;
  localparam logic [63:0] MAX_ORIG   = 64'h8000_0000;
  localparam int          MAX_VEC    = 2048;

  localparam int CTL_EN_BIT   = 31;
  localparam int CTL_MASK_BIT = 30;

  typedef enum logic [1:0] {
    DW_CTRL = 2'd0,
    DW_TBL  = 2'd1,
    DW_PBA  = 2'd2,
    DW_NONE = 2'd3
  } cap_dw_e;

  typedef struct packed {
    logic en;
    logic mask;
  } ctl_bits_t;

  function automatic logic [63:0] adj_size(input logic [63:0] orig);
    if (orig == 64'd0)            return 64'd0;
    else if (orig < PAGE_BYTES)   return PAGE_BYTES;
    else                          return orig;
  endfunction

  function automatic logic [63:0] grown_size(input logic [63:0] orig);
    if (orig == 64'd0) return PAGE_BYTES;
    else               return adj_size(orig) << 1;
  endfunction

  function automatic logic params_bad(input int nvec, input logic [63:0] orig);
    return (nvec < 1) || (nvec > MAX_VEC) || (orig > MAX_ORIG);
  endfunction

endpackage

// File: rtl/msixc_size.sv
module msixc_size
  import msixc_pkg::*;
#(
  parameter int          NUM_VEC   = 8,
  parameter logic [2:0]  BAR_IDX   = 3'd0,
  parameter logic [63:0] ORIG_SIZE = 64'h0
) (
  output logic        err_o,
  output logic [32:0] bar_size_o,
  output logic [31:0] tbl_dw_o,
  output logic [31:0] pba_dw_o
);

  localparam logic        BAD     = params_bad(NUM_VEC, ORIG_SIZE);
  localparam logic [63:0] ADJ     = adj_size(ORIG_SIZE);
  localparam logic [63:0] GROWN   = grown_size(ORIG_SIZE);
  localparam logic [63:0] PBA_OFS = ADJ + PBA_SHIFT;

  always_comb begin
    err_o = BAD;
    if (BAD) begin
      bar_size_o = '0;
      tbl_dw_o   = '0;
      pba_dw_o   = '0;
    end else begin
      bar_size_o = GROWN[32:0];
      tbl_dw_o   = {ADJ[31:3], BAR_IDX};
      pba_dw_o   = {PBA_OFS[31:3], BAR_IDX};
    end
  end

endmodule

// File: rtl/msixc_regs.sv
module msixc_regs
  import msixc_pkg::*;
#(
  parameter int         NUM_VEC  = 8,
  parameter int         CFG_AW   = 6,
  parameter logic [7:0] CAP_PTR  = 8'h40,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              err_i,
  input  logic [31:0]       tbl_dw_i,
  input  logic [31:0]       pba_dw_i,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_hit,
  output ctl_bits_t         ctl_q,
  output logic              ctl_wr,
  output ctl_bits_t         ctl_nxt
);

  localparam int                NDW    = 3;
  localparam logic [CFG_AW-1:0] BASE   = CFG_AW'(CAP_PTR >> 2);
  localparam logic [10:0]       QSIZE  = 11'(NUM_VEC - 1);

  logic [NDW-1:0] sel;
  cap_dw_e        dw_sel;

  for (genvar g = 0; g < NDW; g++) begin : g_dec
    localparam logic [CFG_AW-1:0] ADDR_G = BASE + CFG_AW'(g);
    assign sel[g] = !err_i && (cfg_addr == ADDR_G);
  end

  always_comb begin
    dw_sel = DW_NONE;
    if (sel[0])      dw_sel = DW_CTRL;
    else if (sel[1]) dw_sel = DW_TBL;
    else if (sel[2]) dw_sel = DW_PBA;
  end

  assign cfg_hit = |sel;

  always_comb begin
    unique case (dw_sel)
      DW_CTRL: cfg_rdata = {ctl_q.en, ctl_q.mask, 3'b000, QSIZE, NEXT_PTR, CAP_ID};
      DW_TBL:  cfg_rdata = tbl_dw_i;
      DW_PBA:  cfg_rdata = pba_dw_i;
      default: cfg_rdata = '0;
    endcase
  end

  assign ctl_wr       = cfg_we && sel[0] && cfg_be[3];
  assign ctl_nxt.en   = cfg_wdata[CTL_EN_BIT];
  assign ctl_nxt.mask = cfg_wdata[CTL_MASK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_nxt;
    end
  end

endmodule

// File: rtl/msixc_scan.sv
module msixc_scan
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  ctl_bits_t        ctl_nxt,
  input  logic             rply_ready,
  output logic             rply_valid,
  output logic [VEC_W-1:0] rply_vec,
  output logic             busy,
  output logic             intx_clear
);

  localparam logic [VEC_W-1:0] LAST = VEC_W'(NUM_VEC - 1);

  logic             active_q;
  logic [VEC_W-1:0] idx_q;
  logic             at_last;
  logic             go;

  if (NUM_VEC <= 1) begin : g_single
    assign at_last = 1'b1;
  end else begin : g_multi
    assign at_last = (idx_q == LAST);
  end

  assign go = ctl_nxt.en && !ctl_nxt.mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      idx_q      <= '0;
      intx_clear <= 1'b0;
    end else begin
      intx_clear <= ctl_wr && ctl_nxt.en;
      if (ctl_wr) begin
        active_q <= go;
        idx_q    <= '0;
      end else if (active_q && rply_ready) begin
        if (at_last) begin
          active_q <= 1'b0;
          idx_q    <= '0;
        end else begin
          idx_q <= idx_q + VEC_W'(1);
        end
      end
    end
  end

  assign rply_valid = active_q;
  assign rply_vec   = idx_q;
  assign busy       = active_q;

endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
  import msixc_pkg::*;
#(
  parameter int          NUM_VEC   = 8,
  parameter logic [2:0]  BAR_IDX   = 3'd0,
  parameter logic [63:0] ORIG_SIZE = 64'h0,
  parameter int          CFG_AW    = 6,
  parameter logic [7:0]  CAP_PTR   = 8'h40,
  parameter logic [7:0]  NEXT_PTR  = 8'h00,
  parameter int          VEC_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_hit,
  output logic              cfg_err,
  output logic [32:0]       bar_size,
  output logic              msix_en,
  output logic              mask_all,
  output logic              intx_clear,
  output logic              busy,
  output logic              rply_valid,
  input  logic              rply_ready,
  output logic [VEC_W-1:0]  rply_vec
);

  logic [31:0] tbl_dw;
  logic [31:0] pba_dw;
  ctl_bits_t   ctl_q;
  ctl_bits_t   ctl_nxt;
  logic        ctl_wr;

  msixc_size #(
    .NUM_VEC   (NUM_VEC),
    .BAR_IDX   (BAR_IDX),
    .ORIG_SIZE (ORIG_SIZE)
  ) size_i (
    .err_o      (cfg_err),
    .bar_size_o (bar_size),
    .tbl_dw_o   (tbl_dw),
    .pba_dw_o   (pba_dw)
  );

  msixc_regs #(
    .NUM_VEC  (NUM_VEC),
    .CFG_AW   (CFG_AW),
    .CAP_PTR  (CAP_PTR),
    .NEXT_PTR (NEXT_PTR)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .err_i     (cfg_err),
    .tbl_dw_i  (tbl_dw),
    .pba_dw_i  (pba_dw),
    .cfg_rdata (cfg_rdata),
    .cfg_hit   (cfg_hit),
    .ctl_q     (ctl_q),
    .ctl_wr    (ctl_wr),
    .ctl_nxt   (ctl_nxt)
  );

  msixc_scan #(
    .NUM_VEC (NUM_VEC),
    .VEC_W   (VEC_W)
  ) scan_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_nxt    (ctl_nxt),
    .rply_ready (rply_ready),
    .rply_valid (rply_valid),
    .rply_vec   (rply_vec),
    .busy       (busy),
    .intx_clear (intx_clear)
  );

  assign msix_en  = ctl_q.en;
  assign mask_all = ctl_q.mask;

endmodule

// File: rtl/msixc_chk.sv
module msixc_chk #(
  parameter int         NUM_VEC = 8,
  parameter int         CFG_AW  = 6,
  parameter logic [7:0] CAP_PTR = 8'h40,
  parameter int         VEC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic              cfg_err,
  input logic              msix_en,
  input logic              mask_all,
  input logic              intx_clear,
  input logic              busy,
  input logic              rply_valid,
  input logic              rply_ready,
  input logic [VEC_W-1:0]  rply_vec
);

  localparam logic [CFG_AW-1:0] CTL_DW = CFG_AW'(CAP_PTR >> 2);

  logic ctl_write;
  assign ctl_write = cfg_we && !cfg_err && (cfg_addr == CTL_DW) && cfg_be[3];

  AST_INTX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    intx_clear |-> msix_en);  // R7

  AST_SCAN_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    rply_valid |-> (msix_en && !mask_all));  // R8

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rply_valid |-> (int'(rply_vec) < NUM_VEC));  // R8

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rply_valid && !rply_ready && !ctl_write) |=> (rply_valid && $stable(rply_vec)));  // R9

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rply_valid && rply_ready && !ctl_write && (int'(rply_vec) != NUM_VEC - 1))
      |=> (rply_valid && (rply_vec == $past(rply_vec) + VEC_W'(1))));  // R8

  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && cfg_wdata[31] && !cfg_wdata[30]) |=> (rply_valid && (rply_vec == '0)));  // R10

  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_write |=> ($stable(msix_en) && $stable(mask_all)));  // R11

  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == rply_valid);  // R8

endmodule

bind msix_cap_ctrl msixc_chk #(
  .NUM_VEC (NUM_VEC),
  .CFG_AW  (CFG_AW),
  .CAP_PTR (CAP_PTR),
  .VEC_W   (VEC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_be     (cfg_be),
  .cfg_wdata  (cfg_wdata),
  .cfg_err    (cfg_err),
  .msix_en    (msix_en),
  .mask_all   (mask_all),
  .intx_clear (intx_clear),
  .busy       (busy),
  .rply_valid (rply_valid),
  .rply_ready (rply_ready),
  .rply_vec   (rply_vec)
);

// File: tb/msix_cap_ctrl_tb.sv
module msix_cap_ctrl_tb_top;

  localparam int         N_MAIN = 5;
  localparam logic [7:0] PTR    = 8'h40;
  localparam logic [7:0] NXT    = 8'h50;
  localparam logic [5:0] A_CTL  = 6'h10;
  localparam logic [5:0] A_TBL  = 6'h11;
  localparam logic [5:0] A_PBA  = 6'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rdy = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  logic [31:0] rd_m, rd_z, rd_b, rd_e;
  logic        hit_m, hit_z, hit_b, hit_e;
  logic        err_m, err_z, err_b, err_e;
  logic [32:0] bs_m, bs_z, bs_b, bs_e;
  logic        en_m, mk_m, ix_m, bz_m, v_m;
  logic [2:0]  vec_m;
  logic        en_z, mk_z, ix_z, bz_z, v_z;
  logic [1:0]  vec_z;
  logic        en_b, mk_b, ix_b, bz_b, v_b;
  logic [0:0]  vec_b;
  logic        en_e, mk_e, ix_e, bz_e, v_e;
  logic [1:0]  vec_e;

  msix_cap_ctrl #(.NUM_VEC(N_MAIN), .BAR_IDX(3'd2), .ORIG_SIZE(64'h300),
                  .CFG_AW(6), .CAP_PTR(PTR), .NEXT_PTR(NXT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m), .cfg_hit(hit_m), .cfg_err(err_m),
    .bar_size(bs_m), .msix_en(en_m), .mask_all(mk_m), .intx_clear(ix_m), .busy(bz_m),
    .rply_valid(v_m), .rply_ready(rdy), .rply_vec(vec_m));

  msix_cap_ctrl #(.NUM_VEC(3), .BAR_IDX(3'd0), .ORIG_SIZE(64'h0),
                  .CFG_AW(6), .CAP_PTR(PTR), .NEXT_PTR(NXT)) dut_z (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_z), .cfg_hit(hit_z), .cfg_err(err_z),
    .bar_size(bs_z), .msix_en(en_z), .mask_all(mk_z), .intx_clear(ix_z), .busy(bz_z),
    .rply_valid(v_z), .rply_ready(1'b1), .rply_vec(vec_z));

  msix_cap_ctrl #(.NUM_VEC(1), .BAR_IDX(3'd5), .ORIG_SIZE(64'h10000),
                  .CFG_AW(6), .CAP_PTR(PTR), .NEXT_PTR(NXT)) dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .cfg_hit(hit_b), .cfg_err(err_b),
    .bar_size(bs_b), .msix_en(en_b), .mask_all(mk_b), .intx_clear(ix_b), .busy(bz_b),
    .rply_valid(v_b), .rply_ready(1'b1), .rply_vec(vec_b));

  msix_cap_ctrl #(.NUM_VEC(4), .BAR_IDX(3'd1), .ORIG_SIZE(64'h1_0000_0000),
                  .CFG_AW(6), .CAP_PTR(PTR), .NEXT_PTR(NXT)) dut_e (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_e), .cfg_hit(hit_e), .cfg_err(err_e),
    .bar_size(bs_e), .msix_en(en_e), .mask_all(mk_e), .intx_clear(ix_e), .busy(bz_e),
    .rply_valid(v_e), .rply_ready(1'b1), .rply_vec(vec_e));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl_word(input logic en, input logic mk, input int n);
    return {en, mk, 3'b000, 11'(n - 1), NXT, 8'h11};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [5:0] a);
    cfg_addr = a;
    #1;
  endtask

  // Runs the current scan of dut_i to its end; ready asserted every pat-th cycle.
  task automatic collect(input string req, input int n, input int pat);
    int exp_v = 0;
    int k = 0;
    while (v_m && k < 200) begin
      rdy = (k % pat) == 0;
      if (rdy) begin
        chk(req, 64'(vec_m), 64'(exp_v));
        exp_v++;
      end
      @(negedge clk);
      k++;
    end
    rdy = 1'b0;
    chk({req, " count"}, 64'(exp_v), 64'(n));
    chk({req, " busy low"}, 64'(bz_m), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    rd(A_CTL);
    chk("R6 ctl word", 64'(rd_m), 64'(ctl_word(1'b0, 1'b0, N_MAIN)));
    chk("R6 busy", 64'(bz_m), 64'd0);
    chk("R6 valid", 64'(v_m), 64'd0);
    chk("R6 intx", 64'(ix_m), 64'd0);

    // R1 layout and hit decode
    chk("R1 hit ctl", 64'(hit_m), 64'd1);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a));
      chk("R1 hit decode", 64'(hit_m), 64'((a >= 16 && a <= 18) ? 1 : 0));
      if (a < 16 || a > 18) chk("R1 rdata zero", 64'(rd_m), 64'd0);
    end

    // R3/R4 offsets and sizes for every sizing branch
    rd(A_TBL);
    chk("R3 tbl main", 64'(rd_m), 64'h1002);
    chk("R3 tbl zero", 64'(rd_z), 64'h0);
    chk("R3 tbl big",  64'(rd_b), 64'h10005);
    rd(A_PBA);
    chk("R3 pba main", 64'(rd_m), 64'h1802);
    chk("R3 pba zero", 64'(rd_z), 64'h800);
    chk("R3 pba big",  64'(rd_b), 64'h10805);
    chk("R4 size main", 64'(bs_m), 64'h2000);
    chk("R4 size zero", 64'(bs_z), 64'h1000);
    chk("R4 size big",  64'(bs_b), 64'h20000);
    rd(A_CTL);
    chk("R1 ctl single", 64'(rd_b), 64'(ctl_word(1'b0, 1'b0, 1)));

    // R5 illegal parameters
    chk("R5 err", 64'(err_e), 64'd1);
    chk("R5 size", 64'(bs_e), 64'd0);
    chk("R5 hit", 64'(hit_e), 64'd0);
    chk("R5 rdata", 64'(rd_e), 64'd0);
    chk("R5 err legal", 64'(err_m), 64'd0);

    // R2/R7/R8/R11 sweep over lanes and control values
    for (int v = 0; v < 4; v++) begin
      for (int be = 0; be < 16; be++) begin
        logic en_w, mk_w, taken;
        en_w = v[1]; mk_w = v[0]; taken = be[3];
        wr(A_CTL, 4'b1000, 32'h4000_0000);  // quiesce: disabled, masked
        wr(A_CTL, 4'(be), {en_w, mk_w, 30'h3FFF_FFFF});
        rd(A_CTL);
        chk(taken ? "R2 ctl write" : "R11 lane ignored", 64'(rd_m),
            64'(taken ? ctl_word(en_w, mk_w, N_MAIN) : ctl_word(1'b0, 1'b1, N_MAIN)));
        chk("R7 intx pulse", 64'(ix_m), 64'(taken & en_w));
        chk("R8 scan start", 64'(bz_m), 64'(taken & en_w & ~mk_w));
        chk("R5 err no scan", 64'(bz_e), 64'd0);
        @(negedge clk);
        chk("R7 intx one cycle", 64'(ix_m), 64'd0);
      end
    end

    // R11 other dwords and addresses
    wr(A_CTL, 4'b1000, 32'h0);
    wr(A_TBL, 4'hF, 32'hFFFF_FFFF);
    wr(A_PBA, 4'hF, 32'hFFFF_FFFF);
    wr(6'h20, 4'hF, 32'hFFFF_FFFF);
    rd(A_TBL);
    chk("R11 tbl ro", 64'(rd_m), 64'h1002);
    rd(A_CTL);
    chk("R11 ctl kept", 64'(rd_m), 64'(ctl_word(1'b0, 1'b0, N_MAIN)));
    chk("R11 no scan", 64'(bz_m), 64'd0);
    chk("R11 no intx", 64'(ix_m), 64'd0);

    // R8 scans under several ready patterns; R9 stall hold
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    collect("R8 scan ready always", N_MAIN, 1);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    collect("R9 scan ready alternate", N_MAIN, 2);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    collect("R9 scan ready sparse", N_MAIN, 5);

    // R8 single-vector instance finishes after one accept
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    chk("R8 single valid", 64'(v_b), 64'd1);
    chk("R8 single vec", 64'(vec_b), 64'd0);
    @(negedge clk);
    chk("R8 single done", 64'(v_b), 64'd0);

    // R2 unmask after masked enable
    wr(A_CTL, 4'b1000, 32'hC000_0000);
    chk("R2 masked no scan", 64'(bz_m), 64'd0);
    chk("R7 masked intx", 64'(ix_m), 64'd1);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    collect("R8 scan after unmask", N_MAIN, 1);

    // R10 restart mid-scan
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rdy = 1'b0;
    chk("R10 mid-scan vec", 64'(vec_m), 64'd2);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    chk("R10 restart vec", 64'(vec_m), 64'd0);
    collect("R10 restarted scan", N_MAIN, 1);

    // R10 abort by mask and by disable
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    wr(A_CTL, 4'b1000, 32'hC000_0000);
    chk("R10 mask abort", 64'(v_m), 64'd0);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    wr(A_CTL, 4'b1000, 32'h0000_0000);
    chk("R10 disable abort", 64'(bz_m), 64'd0);

    // R6 reset returns control to zero mid-scan
    wr(A_CTL, 4'b1000, 32'hC000_0000);
    wr(A_CTL, 4'b1000, 32'h8000_0000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(A_CTL);
    chk("R6 reset ctl", 64'(rd_m), 64'(ctl_word(1'b0, 1'b0, N_MAIN)));
    chk("R6 reset busy", 64'(bz_m), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule